// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a synchronous static RAM whose bus needs no idle cycle when the traffic changes direction. Every rising clock edge can accept a new command. The command carries an address, a read/write select, a load strobe, three chip-select inputs and active-low byte write enables. The data phase of each command takes place in the cycle that follows. Read data flows straight from the storage array onto the bus with no output register. Write data is captured at the edge that closes the data phase. Reads and writes can therefore alternate on every cycle.

A clock enable freezes the whole block for a cycle. A separate output enable gates the read drivers. The tri-state bus appears as three ports: a data input, a data output and a drive enable. The data width is set by a lane count and a lane width, and the depth is kept small. The storage array is not reset. Consumers must write a location before they read it.

Top module: `zbt_ft_sram`

## Requirements
- R1: After reset the block drives nothing (`bus_oe` low) and no command is pending.
- R2: A selected read loaded at an enabled edge places the contents of its address on `bus_out` during the next cycle, with `bus_oe` high while `oe_n` is low.
- R3: A selected write loaded at an enabled edge stores `bus_in` into its address at the next enabled edge.
- R4: A command is accepted only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. In the bench this triple is written {sel_a_n,sel_b_n,sel_c}=3'b001. Any other triple issues no operation: no location changes and the bus is not driven in the following cycle.
- R5: Byte lane k occupies bits [k*LANE_W +: LANE_W]. It is written only when `byte_en_n[k]`=0, and the enables are sampled together with the address.
- R6: `oe_n` acts without a clock. While it is high, `bus_oe` is low, even during a read data phase.
- R7: An edge with `cke_n` high is ignored. The pending command and its data phase are held, no location changes, and a held read keeps the same value on `bus_out`. A held write stores the `bus_in` present at the next enabled edge.
- R8: Reads and writes may alternate on consecutive cycles. A read issued directly after a write to the same address returns the newly merged data.
- R9: An enabled edge with `adv_nld` high issues no operation, and the following cycle is not driven.
- R10: `bus_oe` is never high during the data phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low |
| adv_nld | input | 1 | Low loads a new command; high issues nothing |
| rd_nwr | input | 1 | High for read, low for write |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| byte_en_n | input | LANES | Byte-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, active low, unclocked |
| bus_in | input | DATA_W | Data arriving from the bus |
| bus_out | output | DATA_W | Read data toward the bus |
| bus_oe | output | 1 | High when the block drives the bus |

## Verification
The bench targets a write followed at once by a read of the same word. A design that read the array before committing the write would return stale lanes there. Stalls placed inside both read and write data phases expose two faults: a design that drops or advances the pending command under `cke_n`, and one that samples write data at the stalled edge. Every deselecting chip-select triple is applied with a write behind it. A decode fault there would corrupt a word or drive the bus. Toggling `oe_n` during held reads catches an output enable that was wrongly registered.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              adv_nld,
  input  logic              rd_nwr,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic [LANES-1:0]  byte_en_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] op_addr_q,
  output logic [LANES-1:0]  op_ben_n_q
);
  op_e               op_d;
  logic [ADDR_W-1:0] op_addr_d;
  logic [LANES-1:0]  op_ben_n_d;
  logic              chip_on;

  assign chip_on = !sel_a_n && !sel_b_n && sel_c;

  always_comb begin
    op_d       = op_q;
    op_addr_d  = op_addr_q;
    op_ben_n_d = op_ben_n_q;
    if (!cke_n) begin
      if (!adv_nld && chip_on) begin
        op_d       = rd_nwr ? OP_READ : OP_WRITE;
        op_addr_d  = addr;
        op_ben_n_d = byte_en_n;
      end else begin
        op_d = OP_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_IDLE;
      op_addr_q  <= '0;
      op_ben_n_q <= '1;
    end else begin
      op_q       <= op_d;
      op_addr_q  <= op_addr_d;
      op_ben_n_q <= op_ben_n_d;
    end
  end
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && lane_we[g]) begin
        bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end
    assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/zbt_bus_drive.sv
module zbt_bus_drive
  import zbt_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  op_e               op,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  logic rd_phase;

  assign rd_phase = (op == OP_READ);
  assign bus_oe   = rd_phase && !oe_n;
  assign bus_out  = rd_phase ? rd_data : '0;
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
  import zbt_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              adv_nld,
  input  logic              rd_nwr,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic [LANES-1:0]  byte_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  op_e               op_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [LANES-1:0]  op_ben_n_q;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  zbt_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cke_n      (cke_n),
    .adv_nld    (adv_nld),
    .rd_nwr     (rd_nwr),
    .sel_a_n    (sel_a_n),
    .sel_b_n    (sel_b_n),
    .sel_c      (sel_c),
    .byte_en_n  (byte_en_n),
    .addr       (addr),
    .op_q       (op_q),
    .op_addr_q  (op_addr_q),
    .op_ben_n_q (op_ben_n_q)
  );

  // write commits at the edge closing its data phase, if that edge is enabled
  assign wr_en = !cke_n && (op_q == OP_WRITE);

  zbt_mem_array #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .lane_we (~op_ben_n_q),
    .wr_addr (op_addr_q),
    .wr_data (bus_in),
    .rd_addr (op_addr_q),
    .rd_data (rd_data)
  );

  zbt_bus_drive #(.DATA_W(DATA_W)) u_drv (
    .op      (op_q),
    .oe_n    (oe_n),
    .rd_data (rd_data),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );
endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              adv_nld,
  input logic              rd_nwr,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              sel_c,
  input logic              oe_n,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_oe
);
  logic chip_on;
  assign chip_on = !sel_a_n && !sel_b_n && sel_c;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !bus_oe); // R1
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_nld && chip_on && rd_nwr && !oe_n) |=> (bus_oe || oe_n)); // R2
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_nld && !chip_on) |=> !bus_oe); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(bus_out)); // R7
  AST_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_nld) |=> !bus_oe); // R9
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_nld && chip_on && !rd_nwr) |=> !bus_oe); // R10
endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cke_n   (cke_n),
  .adv_nld (adv_nld),
  .rd_nwr  (rd_nwr),
  .sel_a_n (sel_a_n),
  .sel_b_n (sel_b_n),
  .sel_c   (sel_c),
  .oe_n    (oe_n),
  .bus_out (bus_out),
  .bus_oe  (bus_oe)
);

// File: tb/zbt_ft_sram_tb.sv
module zbt_ft_sram_tb;
  localparam int DEPTH = 32;
  localparam int L     = 4;
  localparam int LW    = 9;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = L * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cke_n, adv_nld, rd_nwr, sel_a_n, sel_b_n, sel_c, oe_n;
  logic [L-1:0]  byte_en_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] bus_in, bus_out;
  logic          bus_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DW-1:0] ref_mem [DEPTH];
  int            pend_op;   // 0 idle, 1 read, 2 write
  logic [AW-1:0] pend_addr;
  logic [L-1:0]  pend_ben;

  always #10 clk = ~clk;

  zbt_ft_sram #(.DEPTH(DEPTH), .LANES(L), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_nld(adv_nld), .rd_nwr(rd_nwr),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c), .byte_en_n(byte_en_n),
    .addr(addr), .oe_n(oe_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  function automatic logic [DW-1:0] rnd();
    return DW'({$urandom(), $urandom()});
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [L-1:0] ben_n);
    logic [DW-1:0] r = old_w;
    for (int k = 0; k < L; k++)
      if (!ben_n[k]) r[k*LW +: LW] = new_w[k*LW +: LW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Check the data phase now on the bus, then present one command cycle.
  // ce = {sel_a_n, sel_b_n, sel_c}; din is the data for the pending write.
  task automatic cyc(input logic cke, input logic adv, input logic [2:0] ce,
                     input logic rw, input logic [L-1:0] ben, input logic [AW-1:0] a,
                     input logic oe, input logic [DW-1:0] din, input string tag);
    logic exp_oe;
    exp_oe = (pend_op == 1) && !oe_n;
    chk(bus_oe === exp_oe, tag, "bus_oe", DW'(bus_oe), DW'(exp_oe));
    if (exp_oe)
      chk(bus_out === ref_mem[pend_addr], tag, "bus_out", bus_out, ref_mem[pend_addr]);
    cke_n = cke; adv_nld = adv; {sel_a_n, sel_b_n, sel_c} = ce; rd_nwr = rw;
    byte_en_n = ben; addr = a; oe_n = oe; bus_in = din;
    if (!cke) begin
      if (pend_op == 2) ref_mem[pend_addr] = merge(ref_mem[pend_addr], din, pend_ben);
      if (!adv && ce == 3'b001) begin
        pend_op = rw ? 1 : 2; pend_addr = a; pend_ben = ben;
      end else begin
        pend_op = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic oe, input logic [DW-1:0] din,
                    input string tag);
    cyc(1'b0, 1'b0, 3'b001, 1'b1, '1, a, oe, din, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [L-1:0] ben,
                    input logic [DW-1:0] din, input string tag);
    cyc(1'b0, 1'b0, 3'b001, 1'b0, ben, a, 1'b0, din, tag);
  endtask

  task automatic idle(input logic [DW-1:0] din, input string tag);
    cyc(1'b0, 1'b0, 3'b101, 1'b1, '1, '0, 1'b0, din, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    pend_op = 0; pend_addr = '0; pend_ben = '1;
    rst_n = 1'b0; cke_n = 1'b0; adv_nld = 1'b0; rd_nwr = 1'b1;
    sel_a_n = 1'b1; sel_b_n = 1'b1; sel_c = 1'b0; oe_n = 1'b0;
    byte_en_n = '1; addr = '0; bus_in = '0;
    repeat (3) @(negedge clk);
    chk(bus_oe === 1'b0, "R1", "bus_oe in reset", DW'(bus_oe), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_oe === 1'b0, "R1", "bus_oe after reset", DW'(bus_oe), '0);

    // R3: fill every word back to back, then read every word back to back
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), '0, rnd(), "R3");
    idle(rnd(), "R3");
    for (int i = 0; i < DEPTH; i++) rd(AW'(i), 1'b0, rnd(), "R2");
    idle(rnd(), "R3");

    // R5: partial lanes
    wr(3, 4'b1010, rnd(), "R5"); idle(rnd(), "R5");
    rd(3, 1'b0, rnd(), "R5");    idle(rnd(), "R5");
    wr(3, 4'b0111, rnd(), "R5"); rd(3, 1'b0, rnd(), "R5"); idle(rnd(), "R5");

    // R8: alternate write/read on consecutive cycles, same address
    wr(5, '0, rnd(), "R8");
    rd(5, 1'b0, rnd(), "R8");
    wr(6, 4'b0110, rnd(), "R8");
    rd(6, 1'b0, rnd(), "R8");
    wr(5, 4'b1001, rnd(), "R8");
    rd(5, 1'b0, rnd(), "R8");
    idle(rnd(), "R8");

    // R4: every deselecting triple, with writes and reads
    for (int c = 0; c < 8; c++) begin
      if (c != 1) begin
        cyc(1'b0, 1'b0, 3'(c), 1'b0, '0, 7, 1'b0, rnd(), "R4");
        cyc(1'b0, 1'b0, 3'(c), 1'b1, '1, 7, 1'b0, rnd(), "R4");
      end
    end
    idle(rnd(), "R4");
    rd(7, 1'b0, rnd(), "R4"); idle(rnd(), "R4");

    // R6: output enable high blocks the drive
    rd(2, 1'b1, rnd(), "R6"); rd(2, 1'b0, rnd(), "R6"); idle(rnd(), "R6");

    // R7: stalls inside read and write data phases, oe toggled while held
    rd(4, 1'b0, rnd(), "R7");
    cyc(1'b1, 1'b0, 3'b001, 1'b0, '0, 9, 1'b1, rnd(), "R7");
    cyc(1'b1, 1'b1, 3'b000, 1'b0, '0, 9, 1'b0, rnd(), "R7");
    cyc(1'b1, 1'b0, 3'b001, 1'b1, '0, 1, 1'b0, rnd(), "R7");
    idle(rnd(), "R7");
    wr(9, '0, rnd(), "R7");
    cyc(1'b1, 1'b0, 3'b001, 1'b0, '0, 9, 1'b0, rnd(), "R7");
    cyc(1'b1, 1'b0, 3'b001, 1'b1, '0, 9, 1'b0, rnd(), "R7");
    idle(rnd(), "R7");
    rd(9, 1'b0, rnd(), "R7"); idle(rnd(), "R7");

    // R9: advance cycle issues nothing
    cyc(1'b0, 1'b1, 3'b001, 1'b1, '1, 4, 1'b0, rnd(), "R9");
    idle(rnd(), "R9");
    cyc(1'b0, 1'b1, 3'b001, 1'b0, '0, 4, 1'b0, rnd(), "R9");
    rd(4, 1'b0, rnd(), "R9"); idle(rnd(), "R9");

    // R10: no drive during write data phase
    wr(1, '0, rnd(), "R10"); idle(rnd(), "R10");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ce;
      ce = ($urandom() % 8 == 0) ? 3'($urandom()) : 3'b001;
      cyc(($urandom() % 8) == 0, ($urandom() % 10) == 0, ce, 1'($urandom()),
          ($urandom() % 2) ? '0 : L'($urandom()), AW'($urandom()),
          ($urandom() % 5) == 0, rnd(), "R2");
    end
    idle(rnd(), "R2");
    idle(rnd(), "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule